// File: doc/BRIEF.md
# Port Pin Controller with Peripheral Takeover

This block runs one bank of general-purpose pins. For each pin, software sets a direction bit, an output bit and an input-disable bit. The output bit also requests a pull-up when the pin is an input. The pad value returns through a two-flop synchroniser and can be read through the same register interface.

On-chip peripherals can take a pin away from software. Each pin has an override record with four enable/value pairs, covering:
- pull-up,
- direction,
- driven value,
- digital input enable.

Any field that is not overridden falls back to its register-derived value. The peripherals served are:
- an SPI clock and select pair,
- two timer compare outputs,
- a UART transmit and receive pair,
- the pin-change and external interrupt detectors, which force the digital input on.

The gated, synchronised pin values go back to the peripherals on one bus.

Top module: `gpio_ovr_port`

## Requirements
- R1: Synchronous active-high reset clears the direction, output and input-disable registers, the read data, the synchroniser and all registered pad outputs (drive, enable and pull-up all 0).
- R2: A write with select 0 loads the direction register, select 1 loads the output register and select 3 loads the input-disable register. `rd_data` returns, one clock after `rd_sel` is presented, the direction register (0), the output register (1) or the input-disable register (3).
- R3: A write with select 2 inverts every output-register bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: With no override active, one clock after the registers change:
  - the pad enable equals the direction bit,
  - the pad value equals the output bit,
  - the pull-up is on only when the direction bit is 0, the output bit is 1 and `pull_dis` is 0.
  - A pad never has pull-up and drive enable on together.
- R5: When SPI is on as a slave (`spi_en`=1, `spi_master`=0), the clock pin (pin 7) and select pin (pin 6) are inputs whatever their direction bits hold. Their pull-up is the output bit ANDed with NOT `pull_dis`.
- R6: When SPI is on as a master, pin 7 drives `spi_sck_out` with its direction taken from the direction bit. Pin 6 behaves as a plain port pin.
- R7: A timer compare enable puts `cmp_out[0]` on pin 7 or `cmp_out[1]` on pin 5, with direction still taken from the direction bit. On pin 7, an SPI master clock takes precedence over compare output 0.
- R8: With `uart_tx_en`=1, pin 1 is forced to output, drives `uart_txd` and has its pull-up off.
- R9: With `uart_rx_en`=1, pin 0 is forced to input. Its pull-up is the output bit ANDed with NOT `pull_dis`.
- R10: A pad input level appears on `periph_in` two clocks after it is applied, provided the pin's digital input is enabled.
- R11: A pin whose input-disable bit is 1 reads 0 on `periph_in`, unless the input is forced on. Forcing happens when its `pc_mask` bit and `pc_group_en` are both 1, or, for pin 2 with `xint_en[0]` and pin 3 with `xint_en[1]`, when its external interrupt is enabled.
- R12: Reading select 2 returns, one clock later, the synchronised and input-gated pin values as seen on `periph_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 direction, 1 output, 2 toggle, 3 input disable |
| wr_data | input | WIDTH | Write data |
| rd_sel | input | 2 | Read source: 0 direction, 1 output, 2 pin values, 3 input disable |
| rd_data | output | WIDTH | Registered read data |
| pull_dis | input | 1 | Global pull-up disable |
| spi_en | input | 1 | SPI enabled |
| spi_master | input | 1 | SPI is master |
| spi_sck_out | input | 1 | SPI master clock to drive on pin 7 |
| cmp_en | input | 2 | Timer compare output enables (bit 0 pin 7, bit 1 pin 5) |
| cmp_out | input | 2 | Timer compare output levels |
| uart_tx_en | input | 1 | UART transmitter enabled |
| uart_txd | input | 1 | UART transmit level |
| uart_rx_en | input | 1 | UART receiver enabled |
| pc_mask | input | WIDTH | Per-pin pin-change mask |
| pc_group_en | input | 1 | Pin-change group enable |
| xint_en | input | 2 | External interrupt enables (bit 0 pin 2, bit 1 pin 3) |
| pad_in | input | WIDTH | Pad input levels |
| pad_out | output | WIDTH | Registered pad drive values |
| pad_oe | output | WIDTH | Registered pad output enables |
| pad_pu | output | WIDTH | Registered pad pull-up enables |
| periph_in | output | WIDTH | Synchronised, input-gated pin values for peripherals |

## Verification
The hardest case to reach is the one where several peripherals claim the same pin at once. Examples are an SPI master clock against a compare output on pin 7, or a slave select forcing input while the output bit asks for a pull-up. In those cases the override priority and the pull-up fallback must both come out right.

The bench walks every combination of the seven override controls in turn, randomising register contents, pad levels and peripheral data underneath each one. It then runs a long stretch with everything random, including register writes. A behavioural model checks every pad output, the peripheral bus and the read data on every clock. Input-disable bits are set together with random pin-change masks and interrupt enables, so the forcing of the digital input (R11) is exercised against live pad toggles.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

  typedef enum logic [1:0] {
    SEL_DIR    = 2'd0,
    SEL_PORT   = 2'd1,
    SEL_TOGGLE = 2'd2,
    SEL_DINOFF = 2'd3
  } reg_sel_e;

  // one pin's takeover record: enable/value pairs
  typedef struct packed {
    logic pu_en;
    logic pu_val;
    logic dir_en;
    logic dir_val;
    logic drv_en;
    logic drv_val;
    logic din_en;
    logic din_val;
  } pin_ovr_t;

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_ovr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  input  logic [WIDTH-1:0] pin_val,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] port_q,
  output logic [WIDTH-1:0] dinoff_q,
  output logic [WIDTH-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q    <= '0;
      port_q   <= '0;
      dinoff_q <= '0;
      rd_data  <= '0;
    end else begin
      if (wr_en) begin
        case (reg_sel_e'(wr_sel))
          SEL_DIR:    dir_q    <= wr_data;
          SEL_PORT:   port_q   <= wr_data;
          SEL_TOGGLE: port_q   <= port_q ^ wr_data;
          SEL_DINOFF: dinoff_q <= wr_data;
          default: ;
        endcase
      end
      case (reg_sel_e'(rd_sel))
        SEL_DIR:    rd_data <= dir_q;
        SEL_PORT:   rd_data <= port_q;
        SEL_TOGGLE: rd_data <= pin_val;
        SEL_DINOFF: rd_data <= dinoff_q;
        default:    rd_data <= '0;
      endcase
    end
  end

  // R3: toggle write inverts selected bits only
  p_toggle_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd2) |=> (port_q == ($past(port_q) ^ $past(wr_data))));

  // R2: direction write lands next cycle
  p_dir_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd0) |=> (dir_q == $past(wr_data)));

endmodule

// File: rtl/gpio_ovr_map.sv
module gpio_ovr_map
  import gpio_ovr_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int PIN_SCK   = 7,
  parameter int PIN_SS    = 6,
  parameter int PIN_CMP0  = 7,
  parameter int PIN_CMP1  = 5,
  parameter int PIN_XINT1 = 3,
  parameter int PIN_XINT0 = 2,
  parameter int PIN_TX    = 1,
  parameter int PIN_RX    = 0
) (
  input  logic             [WIDTH-1:0] port_q,
  input  logic                         pull_dis,
  input  logic                         spi_en,
  input  logic                         spi_master,
  input  logic                         spi_sck_out,
  input  logic             [1:0]       cmp_en,
  input  logic             [1:0]       cmp_out,
  input  logic                         uart_tx_en,
  input  logic                         uart_txd,
  input  logic                         uart_rx_en,
  input  logic             [WIDTH-1:0] pc_mask,
  input  logic                         pc_group_en,
  input  logic             [1:0]       xint_en,
  output pin_ovr_t         [WIDTH-1:0] ovr
);

  logic spi_slave, spi_mst;
  assign spi_slave = spi_en & ~spi_master;
  assign spi_mst   = spi_en &  spi_master;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    localparam bit IsSck  = (i == PIN_SCK);
    localparam bit IsSs   = (i == PIN_SS);
    localparam bit IsCmp0 = (i == PIN_CMP0);
    localparam bit IsCmp1 = (i == PIN_CMP1);
    localparam bit IsX0   = (i == PIN_XINT0);
    localparam bit IsX1   = (i == PIN_XINT1);
    localparam bit IsTx   = (i == PIN_TX);
    localparam bit IsRx   = (i == PIN_RX);

    logic held_pu;
    assign held_pu = port_q[i] & ~pull_dis;

    always_comb begin
      ovr[i] = '0;
      ovr[i].din_val = 1'b1;
      ovr[i].din_en  = (pc_mask[i] & pc_group_en)
                     | (IsX0 & xint_en[0]) | (IsX1 & xint_en[1]);
      // lowest priority first; later sources overwrite
      if (IsCmp1 && cmp_en[1]) begin
        ovr[i].drv_en  = 1'b1;
        ovr[i].drv_val = cmp_out[1];
      end
      if (IsCmp0 && cmp_en[0]) begin
        ovr[i].drv_en  = 1'b1;
        ovr[i].drv_val = cmp_out[0];
      end
      if (IsSck && spi_mst) begin
        ovr[i].drv_en  = 1'b1;
        ovr[i].drv_val = spi_sck_out;
      end
      if ((IsSck || IsSs) && spi_slave) begin
        ovr[i].dir_en  = 1'b1;
        ovr[i].dir_val = 1'b0;
        ovr[i].pu_en   = 1'b1;
        ovr[i].pu_val  = held_pu;
      end
      if (IsRx && uart_rx_en) begin
        ovr[i].dir_en  = 1'b1;
        ovr[i].dir_val = 1'b0;
        ovr[i].pu_en   = 1'b1;
        ovr[i].pu_val  = held_pu;
      end
      if (IsTx && uart_tx_en) begin
        ovr[i].dir_en  = 1'b1;
        ovr[i].dir_val = 1'b1;
        ovr[i].drv_en  = 1'b1;
        ovr[i].drv_val = uart_txd;
        ovr[i].pu_en   = 1'b1;
        ovr[i].pu_val  = 1'b0;
      end
    end
  end

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_ovr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  pin_ovr_t [WIDTH-1:0]     ovr,
  input  logic     [WIDTH-1:0]     dir_q,
  input  logic     [WIDTH-1:0]     port_q,
  input  logic     [WIDTH-1:0]     dinoff_q,
  input  logic                     pull_dis,
  output logic     [WIDTH-1:0]     pad_out,
  output logic     [WIDTH-1:0]     pad_oe,
  output logic     [WIDTH-1:0]     pad_pu,
  output logic     [WIDTH-1:0]     din_on
);

  logic [WIDTH-1:0] oe_n, out_n, pu_n;

  for (genvar i = 0; i < WIDTH; i++) begin : g_mux
    logic reg_pu;
    assign reg_pu   = ~dir_q[i] & port_q[i] & ~pull_dis;
    assign oe_n[i]  = ovr[i].dir_en ? ovr[i].dir_val : dir_q[i];
    assign out_n[i] = ovr[i].drv_en ? ovr[i].drv_val : port_q[i];
    assign pu_n[i]  = ovr[i].pu_en  ? ovr[i].pu_val  : reg_pu;
    assign din_on[i] = ovr[i].din_en ? ovr[i].din_val : ~dinoff_q[i];

    // R5: a direction takeover sets the registered enable
    p_dir_ovr_r5: assert property (@(posedge clk) disable iff (rst)
      ovr[i].dir_en |=> (pad_oe[i] == $past(ovr[i].dir_val)));

    // R4: pull-up and drive never together
    p_pu_input_r4: assert property (@(posedge clk) disable iff (rst)
      pad_pu[i] |-> !pad_oe[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
      pad_pu  <= '0;
    end else begin
      pad_out <= out_n;
      pad_oe  <= oe_n;
      pad_pu  <= pu_n;
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else     stage_q[0] <= din;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[k] <= '0;
      else     stage_q[k] <= stage_q[k-1];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PIN_SCK     = 7,
  parameter int PIN_SS      = 6,
  parameter int PIN_CMP0    = 7,
  parameter int PIN_CMP1    = 5,
  parameter int PIN_XINT1   = 3,
  parameter int PIN_XINT0   = 2,
  parameter int PIN_TX      = 1,
  parameter int PIN_RX      = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [WIDTH-1:0] rd_data,
  input  logic             pull_dis,
  input  logic             spi_en,
  input  logic             spi_master,
  input  logic             spi_sck_out,
  input  logic [1:0]       cmp_en,
  input  logic [1:0]       cmp_out,
  input  logic             uart_tx_en,
  input  logic             uart_txd,
  input  logic             uart_rx_en,
  input  logic [WIDTH-1:0] pc_mask,
  input  logic             pc_group_en,
  input  logic [1:0]       xint_en,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pu,
  output logic [WIDTH-1:0] periph_in
);

  logic [WIDTH-1:0] dir_q, port_q, dinoff_q, sync_q, din_on;
  pin_ovr_t [WIDTH-1:0] ovr;

  assign periph_in = sync_q & din_on;

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .pin_val(periph_in), .dir_q(dir_q), .port_q(port_q),
    .dinoff_q(dinoff_q), .rd_data(rd_data)
  );

  gpio_ovr_map #(
    .WIDTH(WIDTH), .PIN_SCK(PIN_SCK), .PIN_SS(PIN_SS), .PIN_CMP0(PIN_CMP0),
    .PIN_CMP1(PIN_CMP1), .PIN_XINT1(PIN_XINT1), .PIN_XINT0(PIN_XINT0),
    .PIN_TX(PIN_TX), .PIN_RX(PIN_RX)
  ) u_map (
    .port_q(port_q), .pull_dis(pull_dis), .spi_en(spi_en),
    .spi_master(spi_master), .spi_sck_out(spi_sck_out), .cmp_en(cmp_en),
    .cmp_out(cmp_out), .uart_tx_en(uart_tx_en), .uart_txd(uart_txd),
    .uart_rx_en(uart_rx_en), .pc_mask(pc_mask), .pc_group_en(pc_group_en),
    .xint_en(xint_en), .ovr(ovr)
  );

  gpio_pin_mux #(.WIDTH(WIDTH)) u_mux (
    .clk(clk), .rst(rst), .ovr(ovr), .dir_q(dir_q), .port_q(port_q),
    .dinoff_q(dinoff_q), .pull_dis(pull_dis), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu), .din_on(din_on)
  );

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pad_in), .dout(sync_q)
  );

  // R5: slave SPI forces both its pins to input
  p_slave_in_r5: assert property (@(posedge clk) disable iff (rst)
    (spi_en && !spi_master) |=> (!pad_oe[PIN_SCK] && !pad_oe[PIN_SS]));

  // R8: transmitter owns its pin
  p_tx_out_r8: assert property (@(posedge clk) disable iff (rst)
    uart_tx_en |=> (pad_oe[PIN_TX] && !pad_pu[PIN_TX] && pad_out[PIN_TX] == $past(uart_txd)));

  // R9: receiver pin is an input
  p_rx_in_r9: assert property (@(posedge clk) disable iff (rst)
    uart_rx_en |=> !pad_oe[PIN_RX]);

  // R6: master clock reaches its pin
  p_sck_drive_r6: assert property (@(posedge clk) disable iff (rst)
    (spi_en && spi_master) |=> (pad_out[PIN_SCK] == $past(spi_sck_out)));

endmodule

// File: tb/tb_gpio_ovr_port.sv
module tb_gpio_ovr_port;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;  // 50 MHz

  logic       wr_en = 0;
  logic [1:0] wr_sel = 0, rd_sel = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       pull_dis = 0, spi_en = 0, spi_master = 0, spi_sck_out = 0;
  logic [1:0] cmp_en = 0, cmp_out = 0, xint_en = 0;
  logic       uart_tx_en = 0, uart_txd = 0, uart_rx_en = 0, pc_group_en = 0;
  logic [7:0] pc_mask = 0, pad_in = 0;
  logic [7:0] pad_out, pad_oe, pad_pu, periph_in;

  gpio_ovr_port dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .pull_dis(pull_dis), .spi_en(spi_en),
    .spi_master(spi_master), .spi_sck_out(spi_sck_out), .cmp_en(cmp_en),
    .cmp_out(cmp_out), .uart_tx_en(uart_tx_en), .uart_txd(uart_txd),
    .uart_rx_en(uart_rx_en), .pc_mask(pc_mask), .pc_group_en(pc_group_en),
    .xint_en(xint_en), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .periph_in(periph_in)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  // reference state
  logic [7:0] m_dir, m_port, m_off, m_s1, m_s2, m_rd, e_oe, e_out, e_pu;

  function automatic bit die(int i);
    return (pc_mask[i] && pc_group_en) || (i == 2 && xint_en[0]) ||
           (i == 3 && xint_en[1]) || !m_off[i];
  endfunction

  function automatic logic [7:0] pins_seen();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = m_s2[i] && die(i);
    return v;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic model_edge();
    logic [7:0] n_oe, n_out, n_pu, n_rd;
    if (rst) begin
      m_dir = 0; m_port = 0; m_off = 0; m_s1 = 0; m_s2 = 0;
      m_rd = 0; e_oe = 0; e_out = 0; e_pu = 0;
      return;
    end
    for (int i = 0; i < 8; i++) begin
      bit oe, o, pu;
      oe = m_dir[i]; o = m_port[i]; pu = !m_dir[i] && m_port[i] && !pull_dis;
      if (i == 5 && cmp_en[1]) o = cmp_out[1];
      if (i == 7) begin
        if (spi_en && spi_master) o = spi_sck_out;
        else if (cmp_en[0]) o = cmp_out[0];
      end
      if ((i == 7 || i == 6) && spi_en && !spi_master) begin
        oe = 0; pu = m_port[i] && !pull_dis;
      end
      if (i == 1 && uart_tx_en) begin oe = 1; o = uart_txd; pu = 0; end
      if (i == 0 && uart_rx_en) begin oe = 0; pu = m_port[0] && !pull_dis; end
      n_oe[i] = oe; n_out[i] = o; n_pu[i] = pu;
    end
    case (rd_sel)
      2'd0: n_rd = m_dir;
      2'd1: n_rd = m_port;
      2'd2: n_rd = pins_seen();
      default: n_rd = m_off;
    endcase
    e_oe = n_oe; e_out = n_out; e_pu = n_pu; m_rd = n_rd;
    m_s2 = m_s1; m_s1 = pad_in;
    if (wr_en) begin
      case (wr_sel)
        2'd0: m_dir = wr_data;
        2'd1: m_port = wr_data;
        2'd2: m_port = m_port ^ wr_data;
        default: m_off = wr_data;
      endcase
    end
  endtask

  function automatic string pin_tag();
    if (uart_tx_en) return "R8";
    if (uart_rx_en) return "R9";
    if (spi_en && !spi_master) return "R5";
    if (spi_en) return "R6";
    if (cmp_en != 0) return "R7";
    return "R4";
  endfunction

  task automatic step();
    string t;
    t = pin_tag();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cycles++;
    if (rst) t = "R1";
    chk({t, " pad_oe"}, pad_oe, e_oe);
    chk({t, " pad_out"}, pad_out, e_out);
    chk({t, " pad_pu"}, pad_pu, e_pu);
    chk((m_off != 0) ? "R11 periph_in" : "R10 periph_in", periph_in, pins_seen());
    chk((rd_sel == 2) ? "R12 rd_data" : "R2 rd_data", rd_data, m_rd);
  endtask

  task automatic rand_data();
    wr_en = ($urandom % 4) == 0; wr_sel = 2'($urandom); wr_data = 8'($urandom);
    rd_sel = 2'($urandom); pad_in = 8'($urandom); pull_dis = 1'($urandom);
    spi_sck_out = 1'($urandom); cmp_out = 2'($urandom); uart_txd = 1'($urandom);
    pc_mask = 8'($urandom); pc_group_en = 1'($urandom); xint_en = 2'($urandom);
  endtask

  initial begin
    repeat (3) step();
    // R1: reset state
    chk("R1 reset oe", pad_oe, 8'h00);
    chk("R1 reset pu", pad_pu, 8'h00);
    chk("R1 reset rd", rd_data, 8'h00);
    rst = 0;
    step();

    // R3: directed toggle
    wr_en = 1; wr_sel = 2'd1; wr_data = 8'h0F; step();
    wr_sel = 2'd2; wr_data = 8'h3C; step();
    wr_en = 0; rd_sel = 2'd1; step(); step();
    chk("R3 toggled port", rd_data, 8'h33);

    // R10: input latency
    rd_sel = 0; wr_en = 1; wr_sel = 2'd3; wr_data = 8'h00; step();
    wr_en = 0; pad_in = 8'hA5; step();
    chk("R10 one clock", periph_in, 8'h00);
    step();
    chk("R10 two clocks", periph_in, 8'hA5);

    // every override combination
    for (int c = 0; c < 128; c++) begin
      spi_en = c[0]; spi_master = c[1]; cmp_en = 2'(c >> 2);
      uart_tx_en = c[4]; uart_rx_en = c[5]; pc_group_en = c[6];
      for (int k = 0; k < 4; k++) begin
        rand_data(); pc_group_en = c[6]; step();
      end
    end

    // fully random stretch
    for (int n = 0; n < 3000; n++) begin
      rand_data();
      spi_en = 1'($urandom); spi_master = 1'($urandom); cmp_en = 2'($urandom);
      uart_tx_en = 1'($urandom); uart_rx_en = 1'($urandom);
      step();
    end

    // R11: input disabled, no forcing, then forced by interrupt on pin 2
    wr_en = 1; wr_sel = 2'd3; wr_data = 8'hFF; pc_group_en = 0; xint_en = 0;
    pad_in = 8'hFF; step();
    wr_en = 0; step(); step();
    chk("R11 disabled reads 0", periph_in, 8'h00);
    xint_en = 2'b01;
    #1 chk("R11 forced pin 2", periph_in, 8'h04);
    step();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule